// File: doc/BRIEF.md
# Checkpointed Undo-Log Memory

This block is a small word-addressed memory that can be rolled back to an earlier consistent state. Time is cut into checkpoint intervals by a free-running counter. Each interval that closes becomes a checkpoint that waits for an external validation. The oldest point that has been confirmed good is the recovery point. Several closed checkpoints may wait for validation at the same time while writes go on in the newest interval.

Storage stays small because only the first write to a word in each interval saves that word's previous contents into a circular undo log. A validate pulse retires the oldest waiting checkpoint. The log entries that belong to the retired interval are then freed from the oldest end, one per cycle. A fault pulse starts a rollback. The log is replayed newest-first, one word per cycle, until the memory again holds exactly the contents it had at the recovery point. Execution then resumes from that point with no checkpoints waiting.

Top module: `ckpt_undo_mem`

## Requirements
- R1: After reset every word reads zero, `busy` is low, `wr_ready` is high, and the recovery point and the current interval are both checkpoint 0.
- R2: A write accepted at a clock edge (`wr_en` and `wr_ready` high, `fault` low) is visible on `rd_data`, which reads `rd_addr` combinationally, right after that edge.
- R3: The interval counter advances on every idle cycle in which `fault` is low. It starts at 0 after reset or after a rollback. `ckpt_start` is high in the cycle in which the counter holds INTERVAL-1 and room is left. At that edge a new interval begins and the counter returns to 0.
- R4: Repeated writes to one word within one interval use at most one log entry, so they never make `wr_ready` fall.
- R5: At most MAX_PEND checkpoints wait for validation. While that many wait, `ckpt_start` stays low and the counter holds at INTERVAL-1 until a validation frees room.
- R6: An idle-cycle `validate` moves the recovery point forward by one checkpoint if any checkpoint is waiting. With none waiting, or in the same cycle as `fault`, it has no effect.
- R7: An idle-cycle `fault` raises `busy` from the next edge for L+1 cycles, where L is the number of log entries that are not yet retired. Afterwards every word equals its value at the recovery point.
- R8: `wr_ready` is low while `busy` is high or while the log holds LOG_DEPTH entries. A write offered while it is low changes nothing.
- R9: After a validation, entries of the retired interval leave the log from the oldest end, one per idle cycle, and this restores `wr_ready` on a full log.
- R10: After a rollback no checkpoint is waiting, the interval counter restarts from 0, and `fault` or `validate` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | Write is accepted this cycle if requested |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Combinational read data |
| validate | input | 1 | Retire the oldest waiting checkpoint |
| fault | input | 1 | Roll back to the recovery point |
| busy | output | 1 | Rollback in progress |
| ckpt_start | output | 1 | A new interval begins at the coming edge |

## Verification
The assertions assume that `rst_n` is held low across the first clock edges and that the inputs only change away from the rising edge. They also assume that `fault` and `validate` may arrive in any cycle, including during a rollback, where the block has to ignore them. The bench drives every input at the falling edge. It mixes random writes, validations and faults, and it also raises faults and validations during rollback and when no checkpoint is waiting, so the "ignored" paths are covered as well. To keep the wrap-around arithmetic of checkpoint numbers valid, the bench never holds more than MAX_PEND checkpoints, which the block enforces by itself.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef enum logic [0:0] {ST_RUN, ST_UNDO} ctl_state_t;

  // Checkpoint numbers need room for the waiting window plus a guard range.
  function automatic int unsigned epoch_bits(input int unsigned max_pend);
    return $clog2(max_pend + 2) + 1;
  endfunction

  // Forward distance from b to a on a ring of 2**w checkpoint numbers.
  function automatic int unsigned ring_dist(input int unsigned a, input int unsigned b,
                                            input int unsigned w);
    int unsigned m;
    m = (32'd1 << w) - 32'd1;
    return (a - b) & m;
  endfunction

  // An entry is retired when its interval lies before the recovery point,
  // that is outside the window [rp, cur] on the ring.
  function automatic logic entry_retired(input int unsigned tag, input int unsigned rp,
                                         input int unsigned cur, input int unsigned w);
    return ring_dist(tag, rp, w) > ring_dist(cur, rp, w);
  endfunction

endpackage

// File: rtl/ckpt_interval_timer.sv
module ckpt_interval_timer #(
  parameter int unsigned INTERVAL = 100000,
  parameter int unsigned MAX_PEND = 4,
  parameter int unsigned EW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_ok,
  input  logic          restart,
  input  logic          advance_rp,
  input  logic          rewind,
  output logic [EW-1:0] cur_epoch,
  output logic [EW-1:0] rp_epoch,
  output logic [EW-1:0] pend,
  output logic          ckpt_start
);
  localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          room;
  logic          at_last;

  assign pend       = cur_epoch - rp_epoch;
  assign room       = pend < EW'(MAX_PEND);
  assign at_last    = cnt == LAST;
  assign ckpt_start = run_ok && at_last && room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (run_ok) begin
      if (!at_last)  cnt <= cnt + 1'b1;
      else if (room) cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_epoch <= '0;
      rp_epoch  <= '0;
    end else begin
      if (rewind)          cur_epoch <= rp_epoch;
      else if (ckpt_start) cur_epoch <= cur_epoch + 1'b1;
      if (advance_rp)      rp_epoch  <= rp_epoch + 1'b1;
    end
  end

  // R5: the waiting window never exceeds its limit
  p_pend_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= EW'(MAX_PEND));

  // R6: the recovery point only ever steps by one
  p_rp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_epoch != $past(rp_epoch)) |-> (rp_epoch == $past(rp_epoch) + EW'(1)));

  // R3: outside a rollback, the current interval only ever steps by one
  p_epoch_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rewind) && cur_epoch != $past(cur_epoch))
      |-> (cur_epoch == $past(cur_epoch) + EW'(1)));

endmodule

// File: rtl/ckpt_undo_log.sv
module ckpt_undo_log #(
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned EW    = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [EW-1:0] push_tag,
  input  logic          pop_newest,
  input  logic          drop_oldest,
  input  logic          clear,
  output logic [AW-1:0] new_addr,
  output logic [DW-1:0] new_data,
  output logic [EW-1:0] new_tag,
  output logic [EW-1:0] old_tag,
  output logic          empty,
  output logic          full
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [EW-1:0] e_tag  [DEPTH];

  logic [IW-1:0] head, tail, newest;
  logic [CW-1:0] count;

  function automatic logic [IW-1:0] idx_next(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IW-1:0] idx_prev(input logic [IW-1:0] i);
    return (i == '0) ? IW'(DEPTH - 1) : i - 1'b1;
  endfunction

  assign newest   = idx_prev(head);
  assign new_addr = e_addr[newest];
  assign new_data = e_data[newest];
  assign new_tag  = e_tag[newest];
  assign old_tag  = e_tag[tail];
  assign empty    = count == '0;
  assign full     = count == CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[head] <= push_addr;
      e_data[head] <= push_data;
      e_tag[head]  <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push)             head <= idx_next(head);
      else if (pop_newest)  head <= newest;
      if (drop_oldest)      tail <= idx_next(tail);
      count <= count + CW'(push) - CW'(pop_newest) - CW'(drop_oldest);
    end
  end

  // R8: nothing is pushed into a full log
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9: entries leave only a non-empty log
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_newest || drop_oldest) |-> !empty);

  // R7: the undo side and the fill side never act together
  p_pop_push_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_newest && push));

endmodule

// File: rtl/ckpt_word_store.sv
module ckpt_word_store #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          restore,
  input  logic [AW-1:0] restore_addr,
  input  logic [DW-1:0] restore_data,
  input  logic          clear_marks,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] prior_data,
  output logic          first_touch
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0]    mem [WORDS];
  logic [WORDS-1:0] touched;

  assign rd_data     = mem[rd_addr];
  assign prior_data  = mem[wr_addr];
  assign first_touch = !touched[wr_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (restore) begin
      mem[restore_addr] <= restore_data;
    end else if (wr) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_marks) touched <= '0;
    else if (wr)               touched[wr_addr] <= 1'b1;
  end

  // R7: restore and normal write never share a cycle
  p_restore_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(restore && wr));

endmodule

// File: rtl/ckpt_undo_mem.sv
module ckpt_undo_mem #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LOG_DEPTH = 16,
  parameter int unsigned MAX_PEND  = 4,
  parameter int unsigned INTERVAL  = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              validate,
  input  logic              fault,
  output logic              busy,
  output logic              ckpt_start
);
  import ckpt_pkg::*;

  localparam int unsigned EW = epoch_bits(MAX_PEND);

  ctl_state_t state;

  logic [EW-1:0]     cur_epoch, rp_epoch, pend;
  logic [ADDR_W-1:0] new_addr;
  logic [DATA_W-1:0] new_data, prior_data;
  logic [EW-1:0]     new_tag, old_tag;
  logic              log_empty, log_full, first_touch;

  // named internal events
  logic idle, wr_fire, fault_fire, val_fire, log_push;
  logic head_live, undo_step, undo_done, purge_fire, clear_marks;

  assign idle       = state == ST_RUN;
  assign busy       = !idle;
  assign wr_ready   = idle && !log_full;
  assign wr_fire    = wr_en && wr_ready && !fault;
  assign fault_fire = fault && idle;
  assign val_fire   = validate && idle && !fault && (pend != '0);
  assign log_push   = wr_fire && first_touch;

  assign head_live  = !log_empty &&
                      !entry_retired(32'(new_tag), 32'(rp_epoch), 32'(cur_epoch), EW);
  assign undo_step  = busy && head_live;
  assign undo_done  = busy && !head_live;
  assign purge_fire = idle && !log_empty &&
                      entry_retired(32'(old_tag), 32'(rp_epoch), 32'(cur_epoch), EW);
  assign clear_marks = ckpt_start || undo_done;

  always_ff @(posedge clk) begin
    if (!rst_n)          state <= ST_RUN;
    else if (fault_fire) state <= ST_UNDO;
    else if (undo_done)  state <= ST_RUN;
  end

  ckpt_interval_timer #(
    .INTERVAL (INTERVAL),
    .MAX_PEND (MAX_PEND),
    .EW       (EW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_ok     (idle && !fault),
    .restart    (fault_fire || undo_done),
    .advance_rp (val_fire),
    .rewind     (undo_done),
    .cur_epoch  (cur_epoch),
    .rp_epoch   (rp_epoch),
    .pend       (pend),
    .ckpt_start (ckpt_start)
  );

  ckpt_undo_log #(
    .AW    (ADDR_W),
    .DW    (DATA_W),
    .EW    (EW),
    .DEPTH (LOG_DEPTH)
  ) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (log_push),
    .push_addr   (wr_addr),
    .push_data   (prior_data),
    .push_tag    (cur_epoch),
    .pop_newest  (undo_step),
    .drop_oldest (purge_fire),
    .clear       (undo_done),
    .new_addr    (new_addr),
    .new_data    (new_data),
    .new_tag     (new_tag),
    .old_tag     (old_tag),
    .empty       (log_empty),
    .full        (log_full)
  );

  ckpt_word_store #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (wr_fire),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .restore      (undo_step),
    .restore_addr (new_addr),
    .restore_data (new_data),
    .clear_marks  (clear_marks),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .prior_data   (prior_data),
    .first_touch  (first_touch)
  );

  // R7: an accepted fault makes the block busy at the next edge
  p_fault_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> busy);

  // R10: a finished rollback leaves nothing waiting and the block idle
  p_rollback_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    undo_done |=> (!busy && pend == '0 && log_empty));

  // R8: while busy no write reaches the store
  p_busy_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !log_push && !wr_fire);

endmodule

// File: tb/test_ckpt_undo_mem.sv
module test_ckpt_undo_mem;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int LD = 6;
  localparam int MP = 3;
  localparam int IV = 20;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          validate = 1'b0;
  logic          fault = 1'b0;
  logic          busy;
  logic          ckpt_start;

  always #5 clk = ~clk;

  ckpt_undo_mem #(
    .ADDR_W (AW), .DATA_W (DW), .LOG_DEPTH (LD), .MAX_PEND (MP), .INTERVAL (IV)
  ) i_ckpt_undo_mem (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .wr_ready (wr_ready), .rd_addr (rd_addr),
    .rd_data (rd_data), .validate (validate), .fault (fault),
    .busy (busy), .ckpt_start (ckpt_start)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  string phase = "";

  // reference model
  logic [DW-1:0] m_mem [NW];
  logic [DW-1:0] snap [16][NW];
  bit            m_mark [NW];
  int            m_cnt, m_cur, m_rp, m_left;
  bit            m_busy;
  int            lq[$];

  function automatic string lbl(input string dflt);
    return (phase != "") ? phase : dflt;
  endfunction

  function automatic int live_entries();
    int n = 0;
    foreach (lq[i]) if (lq[i] >= m_rp) n++;
    return n;
  endfunction

  function automatic bit start_expected(input bit flt);
    return !m_busy && !flt && m_cnt == IV - 1 && (m_cur - m_rp) < MP;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check, advance the model past the rising edge.
  task automatic cyc(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input bit val, input bit flt, input logic [AW-1:0] ra);
    bit rdy, st, wfire, vfire, purge;
    wr_en = we; wr_addr = wa; wr_data = wd; validate = val; fault = flt; rd_addr = ra;
    #1;
    rdy = !m_busy && lq.size() < LD;
    st  = start_expected(flt);
    chk(lbl("R7"), "busy", 32'(busy), 32'(m_busy));
    chk(lbl("R8"), "wr_ready", 32'(wr_ready), 32'(rdy));
    chk(lbl((m_cur - m_rp) == MP ? "R5" : "R3"), "ckpt_start", 32'(ckpt_start), 32'(st));
    if (!m_busy) chk(lbl("R2"), "rd_data", 32'(rd_data), 32'(m_mem[ra]));
    if (!m_busy) begin
      wfire = we && rdy && !flt;
      vfire = val && !flt && (m_cur > m_rp);
      purge = lq.size() > 0 && lq[0] < m_rp;
      if (purge) void'(lq.pop_front());
      if (wfire) begin
        if (!m_mark[wa]) begin lq.push_back(m_cur); m_mark[wa] = 1; end
        m_mem[wa] = wd;
      end
      if (flt) m_cnt = 0;
      else if (m_cnt != IV - 1) m_cnt++;
      else if (st) m_cnt = 0;
      if (st) begin
        m_cur++;
        for (int a = 0; a < NW; a++) begin snap[m_cur % 16][a] = m_mem[a]; m_mark[a] = 0; end
      end
      if (vfire) m_rp++;
      if (flt) begin m_busy = 1; m_left = live_entries(); end
    end else if (m_left > 0) begin
      m_left--;
    end else begin
      m_busy = 0;
      lq.delete();
      m_cur = m_rp;
      m_cnt = 0;
      for (int a = 0; a < NW; a++) begin m_mem[a] = snap[m_rp % 16][a]; m_mark[a] = 0; end
    end
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, 0, AW'($urandom));
  endtask

  task automatic sweep();
    for (int a = 0; a < NW; a++) cyc(0, '0, '0, 0, 0, AW'(a));
  endtask

  task automatic rollback(input string tag);
    phase = tag;
    cyc(0, '0, '0, 0, 1, '0);
    while (m_busy) cyc(1, AW'($urandom), DW'($urandom), 1, 1, '0);
    sweep();
  endtask

  initial begin
    for (int a = 0; a < NW; a++) begin m_mem[a] = '0; snap[0][a] = '0; m_mark[a] = 0; end
    m_cnt = 0; m_cur = 0; m_rp = 0; m_left = 0; m_busy = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    phase = "R1";
    sweep();

    phase = "R2";
    for (int i = 0; i < 30; i++) cyc(($urandom % 2) == 0, AW'($urandom), DW'($urandom), 0, 0, AW'($urandom));

    phase = "R4";
    for (int i = 0; i < 45; i++) cyc(1, AW'(3), DW'($urandom), 0, 0, AW'(3));
    rollback("R4");

    phase = "R5";
    for (int i = 0; i < 110; i++) cyc(($urandom % 4) == 0, AW'($urandom), DW'($urandom), 0, 0, AW'($urandom));

    phase = "R8";
    for (int i = 0; i < 30; i++) cyc(1, AW'($urandom), DW'($urandom), 0, 0, AW'($urandom));

    phase = "R9";
    for (int i = 0; i < 3; i++) cyc(0, '0, '0, 1, 0, '0);
    idle_cycles(12);

    phase = "R7";
    for (int i = 0; i < 25; i++) cyc(($urandom % 2) == 0, AW'($urandom), DW'($urandom), 0, 0, AW'($urandom));
    rollback("R7");

    phase = "R6";
    cyc(0, '0, '0, 1, 0, '0);
    for (int i = 0; i < 10; i++) cyc(1, AW'($urandom), DW'($urandom), 0, 0, AW'($urandom));
    cyc(0, '0, '0, 1, 1, '0);
    while (m_busy) cyc(0, '0, '0, 0, 0, '0);
    sweep();

    phase = "R10";
    for (int i = 0; i < 8; i++) cyc(1, AW'(i), DW'($urandom), 0, 0, '0);
    rollback("R10");
    idle_cycles(IV + 3);

    phase = "";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 100;
      cyc(r < 55, AW'($urandom), DW'($urandom), (r % 16) == 5, r == 99, AW'($urandom));
    end
    while (m_busy) cyc(0, '0, '0, 0, 0, '0);
    rollback("R7");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule